// File: doc/BRIEF.md
# Capture/Reload/Baud Timer

A 16-bit event timer with a companion 16-bit hold register, intended as the third timer beside a small controller core. It advances either once per machine-cycle tick or once per falling edge on an external count pin. When it wraps, it either rolls to zero (capture operation) or reloads its start value from the hold register (auto-reload operation). A falling edge on a separate trigger pin either snapshots the running count into the hold register or forces an immediate reload, depending on the operation selected.

When either of two routing bits is set, the timer becomes a baud source for a serial port. Every wrap reloads from the hold register and produces a single-cycle pulse. The routing bits send that pulse to the receive clock, the transmit clock, or both. A clock whose routing bit is clear follows the overflow strobe of a neighbouring timer instead. While the timer feeds the serial port, its own overflow flag and its trigger response are suppressed. Software reaches everything through a byte-wide write port and a separate read select.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset the control byte, count and hold register all read 0x00, and both flags, the interrupt request and both pulse outputs are 0.
- R2: With the run bit (control bit 0) at 0 and no trigger enabled, the count does not change, whatever ticks arrive.
- R3: With control bit 1 at 0 the count advances on each cycle where `tick` is 1. With control bit 1 at 1 it ignores `tick` and advances once per falling edge of `cnt_pin`.
- R4: In capture operation (control bit 2 = 1, bits 4 and 5 = 0), an advance from 0xFFFF gives 0x0000, sets the overflow flag (control bit 7), and leaves the hold register unchanged.
- R5: In auto-reload operation (control bit 2 = 0, bits 4 and 5 = 0), an advance from 0xFFFF loads the hold register value into the count and sets the overflow flag.
- R6: In capture operation with trigger enable (control bit 3) at 1, a falling edge on `trig_pin` copies the count into the hold register and sets the trigger flag (control bit 6), and counting goes on.
- R7: In auto-reload operation with trigger enable at 1, a falling edge on `trig_pin` loads the count from the hold register and sets the trigger flag.
- R8: A `trig_pin` edge has no effect on count, hold register or trigger flag while trigger enable is 0, or while control bit 4 or 5 is 1.
- R9: With control bit 4 (receive route) or bit 5 (transmit route) at 1, each wrap reloads the count from the hold register and, in the next cycle, drives a one-cycle pulse on every routed clock output. The overflow flag is never set in this operation.
- R10: A clock output whose route bit is 0 follows `t1_ovf` in the same cycle.
- R11: `irq` is the OR of the two flags. The flags stay set until software writes the control byte. A flag set by hardware in the cycle of that write still ends up set.
- R12: A wrap and a qualifying trigger edge in the same cycle both take effect. In capture operation the hold register receives 0xFFFF, the count becomes 0x0000, and both flags are set. In auto-reload operation the count is loaded from the hold register, and both flags are set.
- R13: Address 0 holds the control byte, addresses 1/2 the count low/high bytes, and addresses 3/4 the hold low/high bytes. Other addresses read 0x00 and ignore writes. A byte write to the count or hold register takes priority over any hardware update of that register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Machine-cycle strobe for timer operation |
| cnt_pin | input | 1 | External event pin, counted on falling edges |
| trig_pin | input | 1 | External trigger pin, acts on falling edges |
| t1_ovf | input | 1 | Overflow strobe from the neighbouring timer |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_sel | input | 3 | Register read address |
| rd_data | output | 8 | Read data for `rd_sel` |
| ovf_flag | output | 1 | Overflow flag |
| trig_flag | output | 1 | Trigger flag |
| irq | output | 1 | Interrupt request |
| rx_clk_pulse | output | 1 | Receive baud clock pulse |
| tx_clk_pulse | output | 1 | Transmit baud clock pulse |

## Verification
A counter wrap and a trigger edge can land in the same clock cycle. In capture operation the snapshot must then take the pre-wrap value while the count rolls to zero. In auto-reload operation both causes request the same reload, and both flags must be raised. The bench forces this case directly: it preloads 0xFFFF and drops the trigger pin in the tick cycle, then reads back count, hold register and control byte. The random phase also produces the case, together with software writes colliding with hardware updates. A cycle-accurate reference model in the bench judges every cycle.

// File: rtl/crt_pkg.sv
package crt_pkg;

    localparam int BYTE_W = 8;

    // Control byte layout, MSB first: bit 7 overflow flag .. bit 0 run.
    typedef struct packed {
        logic ovf;
        logic trig;
        logic tx_route;
        logic rx_route;
        logic ext_en;
        logic cap_mode;
        logic count_ext;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // The timer is a baud source whenever either serial clock is routed to it.
    function automatic logic feeds_serial(ctrl_t c);
        return c.rx_route | c.tx_route;
    endfunction

    // Hardware flag sets dominate over a software write in the same cycle.
    function automatic ctrl_t merge_flags(ctrl_t base, logic ovf_set, logic trig_set);
        ctrl_t r;
        r      = base;
        r.ovf  = base.ovf  | ovf_set;
        r.trig = base.trig | trig_set;
        return r;
    endfunction

endpackage

// File: rtl/crt_edge_det.sv
module crt_edge_det #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    logic [N-1:0] pin_q;

    for (genvar i = 0; i < N; i++) begin : g_pin
        always_ff @(posedge clk) begin
            if (rst) pin_q[i] <= 1'b0;
            else     pin_q[i] <= pin[i];
        end
        assign fall[i] = pin_q[i] & ~pin[i];
    end
endmodule

// File: rtl/crt_counter.sv
module crt_counter #(
    parameter int CW = 16,
    localparam int BYTES = CW / crt_pkg::BYTE_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cnt_en,
    input  logic                      cap_mode,
    input  logic                      baud,
    input  logic                      trig_hit,
    input  logic [BYTES-1:0]          cnt_wr_mask,
    input  logic [BYTES-1:0]          hold_wr_mask,
    input  logic [crt_pkg::BYTE_W-1:0] wr_data,
    output logic [CW-1:0]             cnt,
    output logic [CW-1:0]             hold,
    output logic                      ovf_evt
);
    import crt_pkg::*;

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    logic [CW-1:0] cnt_q, cnt_d, hold_q, hold_d;
    logic          cnt_wr_any, hold_wr_any;
    logic          step, at_max, reload_wrap, reload_trig, capture;

    assign cnt_wr_any  = |cnt_wr_mask;
    assign hold_wr_any = |hold_wr_mask;
    assign at_max      = &cnt_q;

    // A software write to the count freezes all hardware activity on it.
    assign step        = cnt_en & ~cnt_wr_any;
    assign ovf_evt     = step & at_max;
    assign reload_wrap = ovf_evt & (baud | ~cap_mode);
    assign reload_trig = trig_hit & ~cap_mode & ~cnt_wr_any;
    assign capture     = trig_hit & cap_mode & ~hold_wr_any;

    always_comb begin
        cnt_d = cnt_q;
        if (step)                       cnt_d = cnt_q + ONE;
        if (reload_wrap || reload_trig) cnt_d = hold_q;
        for (int b = 0; b < BYTES; b++) begin
            if (cnt_wr_mask[b]) cnt_d[b*BYTE_W +: BYTE_W] = wr_data;
        end
    end

    always_comb begin
        hold_d = hold_q;
        if (capture) hold_d = cnt_q;
        for (int b = 0; b < BYTES; b++) begin
            if (hold_wr_mask[b]) hold_d[b*BYTE_W +: BYTE_W] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            hold_q <= '0;
        end else begin
            cnt_q  <= cnt_d;
            hold_q <= hold_d;
        end
    end

    assign cnt  = cnt_q;
    assign hold = hold_q;

    // R4: a capture-mode wrap lands on zero unless software overwrote the count
    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && cap_mode && !baud && !trig_hit) |=> (cnt_q == '0));

    // R9: a wrap while feeding the serial port reloads the hold value
    p_baud_reload_r9: assert property (@(posedge clk) disable iff (rst)
        (ovf_evt && baud && !hold_wr_any) |=> (cnt_q == $past(hold_q)));
endmodule

// File: rtl/crt_ctrl.sv
module crt_ctrl (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_ctrl,
    input  logic [crt_pkg::CTRL_W-1:0] wr_data,
    input  logic                       ovf_evt,
    input  logic                       trig_fall,
    input  logic                       t1_ovf,
    output crt_pkg::ctrl_t             ctrl,
    output logic                       baud,
    output logic                       trig_hit,
    output logic                       irq,
    output logic                       rx_pulse,
    output logic                       tx_pulse
);
    import crt_pkg::*;

    ctrl_t ctrl_q, ctrl_base, ctrl_d;
    logic  strobe_q;
    logic  ovf_set;

    assign baud     = feeds_serial(ctrl_q);
    assign trig_hit = ctrl_q.ext_en & ~baud & trig_fall;
    assign ovf_set  = ovf_evt & ~baud;

    always_comb begin
        ctrl_base = wr_ctrl ? ctrl_t'(wr_data) : ctrl_q;
        ctrl_d    = merge_flags(ctrl_base, ovf_set, trig_hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            strobe_q <= 1'b0;
        end else begin
            ctrl_q   <= ctrl_d;
            strobe_q <= ovf_evt & baud;
        end
    end

    assign ctrl     = ctrl_q;
    assign irq      = ctrl_q.ovf | ctrl_q.trig;
    assign rx_pulse = ctrl_q.rx_route ? strobe_q : t1_ovf;
    assign tx_pulse = ctrl_q.tx_route ? strobe_q : t1_ovf;

    // R11: flags only drop through a software write of the control byte
    p_ovf_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.ovf) |-> $past(wr_ctrl));
    p_trig_clear_r11: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl_q.trig) |-> $past(wr_ctrl));

    // R9: overflow flag never rises from a wrap taken while feeding the serial port
    p_no_ovf_baud_r9: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl_q.ovf) && !$past(wr_ctrl)) |-> !$past(baud));

    // R8: the trigger flag never rises from hardware while in baud operation
    p_no_trig_baud_r8: assert property (@(posedge clk) disable iff (rst)
        ($rose(ctrl_q.trig) && !$past(wr_ctrl)) |-> !$past(baud));
endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer #(
    parameter int AW = 3,
    parameter int CW = 16
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       tick,
    input  logic                       cnt_pin,
    input  logic                       trig_pin,
    input  logic                       t1_ovf,
    input  logic                       wr_en,
    input  logic [AW-1:0]              wr_addr,
    input  logic [crt_pkg::BYTE_W-1:0] wr_data,
    input  logic [AW-1:0]              rd_sel,
    output logic [crt_pkg::BYTE_W-1:0] rd_data,
    output logic                       ovf_flag,
    output logic                       trig_flag,
    output logic                       irq,
    output logic                       rx_clk_pulse,
    output logic                       tx_clk_pulse
);
    import crt_pkg::*;

    localparam int BYTES     = CW / BYTE_W;
    localparam int CTRL_ADDR = 0;
    localparam int CNT_BASE  = 1;
    localparam int HOLD_BASE = CNT_BASE + BYTES;

    ctrl_t             ctrl;
    logic              baud, trig_hit, cnt_en, ovf_evt;
    logic [1:0]        pins, falls;
    logic [BYTES-1:0]  cnt_wr_mask, hold_wr_mask;
    logic [CW-1:0]     cnt, hold;
    logic              wr_ctrl;

    assign pins = {trig_pin, cnt_pin};

    crt_edge_det #(.N(2)) u_edges (
        .clk  (clk),
        .rst  (rst),
        .pin  (pins),
        .fall (falls)
    );

    assign wr_ctrl = wr_en && (wr_addr == AW'(CTRL_ADDR));

    for (genvar b = 0; b < BYTES; b++) begin : g_dec
        assign cnt_wr_mask[b]  = wr_en && (wr_addr == AW'(CNT_BASE + b));
        assign hold_wr_mask[b] = wr_en && (wr_addr == AW'(HOLD_BASE + b));
    end

    crt_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wr_data   (wr_data),
        .ovf_evt   (ovf_evt),
        .trig_fall (falls[1]),
        .t1_ovf    (t1_ovf),
        .ctrl      (ctrl),
        .baud      (baud),
        .trig_hit  (trig_hit),
        .irq       (irq),
        .rx_pulse  (rx_clk_pulse),
        .tx_pulse  (tx_clk_pulse)
    );

    assign cnt_en = ctrl.run & (ctrl.count_ext ? falls[0] : tick);

    crt_counter #(.CW(CW)) u_count (
        .clk          (clk),
        .rst          (rst),
        .cnt_en       (cnt_en),
        .cap_mode     (ctrl.cap_mode),
        .baud         (baud),
        .trig_hit     (trig_hit),
        .cnt_wr_mask  (cnt_wr_mask),
        .hold_wr_mask (hold_wr_mask),
        .wr_data      (wr_data),
        .cnt          (cnt),
        .hold         (hold),
        .ovf_evt      (ovf_evt)
    );

    always_comb begin
        rd_data = '0;
        if (rd_sel == AW'(CTRL_ADDR)) rd_data = ctrl;
        for (int b = 0; b < BYTES; b++) begin
            if (rd_sel == AW'(CNT_BASE + b))  rd_data = cnt[b*BYTE_W +: BYTE_W];
            if (rd_sel == AW'(HOLD_BASE + b)) rd_data = hold[b*BYTE_W +: BYTE_W];
        end
    end

    assign ovf_flag  = ctrl.ovf;
    assign trig_flag = ctrl.trig;

    // R2: stopped timer with no trigger path keeps its count
    p_count_idle_r2: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !ctrl.ext_en && !(|cnt_wr_mask)) |=> $stable(cnt));

    // R8: without trigger enable the hold register only moves by software
    p_hold_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.ext_en && !(|hold_wr_mask)) |=> $stable(hold));

    // R11: interrupt request tracks the flags
    p_irq_flags_r11: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> (ovf_flag || trig_flag));
endmodule

// File: tb/cap_reload_timer_bench.sv
`timescale 1ns/1ps
module cap_reload_timer_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0, cnt_pin = 1'b1, trig_pin = 1'b1, t1_ovf = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       ovf_flag, trig_flag, irq, rx_clk_pulse, tx_clk_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // reference state
    logic [7:0]  m_ctrl = '0;
    logic [15:0] m_cnt = '0, m_hold = '0;
    logic        m_strobe = 1'b0, m_cq = 1'b0, m_tq = 1'b0;

    always #2.5 clk = ~clk;

    cap_reload_timer u_cap_reload_timer (
        .clk(clk), .rst(rst), .tick(tick), .cnt_pin(cnt_pin), .trig_pin(trig_pin),
        .t1_ovf(t1_ovf), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .ovf_flag(ovf_flag), .trig_flag(trig_flag),
        .irq(irq), .rx_clk_pulse(rx_clk_pulse), .tx_clk_pulse(tx_clk_pulse)
    );

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_read(logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_cnt[7:0];
            3'd2: return m_cnt[15:8];
            3'd3: return m_hold[7:0];
            3'd4: return m_hold[15:8];
            default: return 8'h00;
        endcase
    endfunction

    // one clock: inputs already driven; compute model, clock, compare at negedge
    task automatic cyc();
        logic        baud, cfall, tfall, cw, hw, stp, ovf, thit;
        logic [15:0] n_cnt, n_hold;
        logic [7:0]  n_ctrl;
        baud  = m_ctrl[4] | m_ctrl[5];
        cfall = m_cq & ~cnt_pin;
        tfall = m_tq & ~trig_pin;
        cw    = wr_en && (wr_addr == 3'd1 || wr_addr == 3'd2);
        hw    = wr_en && (wr_addr == 3'd3 || wr_addr == 3'd4);
        stp   = m_ctrl[0] && (m_ctrl[1] ? cfall : tick) && !cw;
        ovf   = stp && (m_cnt == 16'hFFFF);
        thit  = m_ctrl[3] && !baud && tfall;
        n_cnt = m_cnt;
        if (stp) n_cnt = m_cnt + 16'd1;
        if ((ovf && (baud || !m_ctrl[2])) || (thit && !m_ctrl[2] && !cw)) n_cnt = m_hold;
        if (wr_en && wr_addr == 3'd1) n_cnt[7:0]  = wr_data;
        if (wr_en && wr_addr == 3'd2) n_cnt[15:8] = wr_data;
        n_hold = m_hold;
        if (thit && m_ctrl[2] && !hw) n_hold = m_cnt;
        if (wr_en && wr_addr == 3'd3) n_hold[7:0]  = wr_data;
        if (wr_en && wr_addr == 3'd4) n_hold[15:8] = wr_data;
        n_ctrl = (wr_en && wr_addr == 3'd0) ? wr_data : m_ctrl;
        n_ctrl[7] = n_ctrl[7] | (ovf && !baud);
        n_ctrl[6] = n_ctrl[6] | thit;
        @(posedge clk);
        m_ctrl = n_ctrl; m_cnt = n_cnt; m_hold = n_hold;
        m_strobe = ovf && baud; m_cq = cnt_pin; m_tq = trig_pin;
        @(negedge clk);
        chk("R11 ovf flag", 16'(ovf_flag), 16'(m_ctrl[7]));
        chk("R11 trig flag", 16'(trig_flag), 16'(m_ctrl[6]));
        chk("R11 irq", 16'(irq), 16'(m_ctrl[7] | m_ctrl[6]));
        chk("R10 rx pulse", 16'(rx_clk_pulse), 16'(m_ctrl[4] ? m_strobe : t1_ovf));
        chk("R10 tx pulse", 16'(tx_clk_pulse), 16'(m_ctrl[5] ? m_strobe : t1_ovf));
        chk("R13 readback", 16'(rd_data), 16'(exp_read(rd_sel)));
    endtask

    task automatic quiet();
        tick = 1'b0; wr_en = 1'b0; cnt_pin = 1'b1; trig_pin = 1'b1; t1_ovf = 1'b0;
    endtask

    task automatic wreg(logic [2:0] a, logic [7:0] d);
        quiet();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        cyc();
        wr_en = 1'b0;
    endtask

    task automatic rdchk(string tag, logic [2:0] a, logic [7:0] exp);
        rd_sel = a;
        #0.1;
        chk(tag, 16'(rd_data), 16'(exp));
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0A17);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        for (int a = 0; a < 5; a++) rdchk("R1 reset reg", 3'(a), 8'h00);
        chk("R1 irq", 16'(irq), 16'd0);
        chk("R1 rx", 16'(rx_clk_pulse), 16'd0);

        // R4 and R3: capture wrap on ticks
        wreg(3'd1, 8'hFE); wreg(3'd2, 8'hFF); wreg(3'd0, 8'h05);
        quiet(); tick = 1'b1; cyc(); cyc(); quiet();
        rdchk("R4 count lo", 3'd1, 8'h00); rdchk("R4 count hi", 3'd2, 8'h00);
        rdchk("R4 hold", 3'd3, 8'h00);
        rdchk("R4 ctrl", 3'd0, 8'h85);

        // R11: software clear
        wreg(3'd0, 8'h00);
        chk("R11 cleared irq", 16'(irq), 16'd0);

        // R5: auto-reload wrap
        wreg(3'd3, 8'h34); wreg(3'd4, 8'h12); wreg(3'd1, 8'hFF); wreg(3'd2, 8'hFF);
        wreg(3'd0, 8'h01);
        quiet(); tick = 1'b1; cyc(); quiet();
        rdchk("R5 count lo", 3'd1, 8'h34); rdchk("R5 count hi", 3'd2, 8'h12);
        chk("R5 ovf", 16'(ovf_flag), 16'd1);

        // R2: stopped
        wreg(3'd0, 8'h00);
        quiet(); tick = 1'b1; cyc(); cyc(); cyc(); quiet();
        rdchk("R2 count", 3'd1, 8'h34);

        // R3: event counting
        wreg(3'd1, 8'h00); wreg(3'd2, 8'h00); wreg(3'd0, 8'h03);
        quiet(); tick = 1'b1; cyc(); cyc(); cyc();
        rdchk("R3 ticks ignored", 3'd1, 8'h00);
        cnt_pin = 1'b0; cyc(); cnt_pin = 1'b1; cyc(); cnt_pin = 1'b0; cyc(); quiet(); cyc();
        rdchk("R3 edges counted", 3'd1, 8'h02);

        // R6: capture on trigger
        wreg(3'd0, 8'h00); wreg(3'd1, 8'h78); wreg(3'd2, 8'h56); wreg(3'd0, 8'h0D);
        quiet(); trig_pin = 1'b0; cyc(); quiet(); cyc();
        rdchk("R6 hold lo", 3'd3, 8'h78); rdchk("R6 hold hi", 3'd4, 8'h56);
        chk("R6 trig flag", 16'(trig_flag), 16'd1);

        // R7: reload on trigger
        wreg(3'd0, 8'h00); wreg(3'd1, 8'h05); wreg(3'd2, 8'h00); wreg(3'd0, 8'h09);
        quiet(); trig_pin = 1'b0; cyc(); quiet(); cyc();
        rdchk("R7 count lo", 3'd1, 8'h78); rdchk("R7 count hi", 3'd2, 8'h56);
        chk("R7 trig flag", 16'(trig_flag), 16'd1);

        // R8: trigger ignored without enable and in baud operation
        wreg(3'd0, 8'h00); wreg(3'd1, 8'h05); wreg(3'd2, 8'h00); wreg(3'd0, 8'h05);
        quiet(); trig_pin = 1'b0; cyc(); quiet(); cyc();
        rdchk("R8 hold kept", 3'd3, 8'h78);
        chk("R8 no flag", 16'(trig_flag), 16'd0);
        wreg(3'd0, 8'h1D);
        quiet(); trig_pin = 1'b0; cyc(); quiet(); cyc();
        rdchk("R8 baud hold kept", 3'd3, 8'h78);
        rdchk("R8 baud count kept", 3'd1, 8'h05);
        chk("R8 baud no flag", 16'(trig_flag), 16'd0);

        // R9: baud operation
        wreg(3'd0, 8'h00); wreg(3'd3, 8'hF0); wreg(3'd4, 8'hFF);
        wreg(3'd1, 8'hFF); wreg(3'd2, 8'hFF); wreg(3'd0, 8'h31);
        quiet(); tick = 1'b1; cyc(); quiet();
        chk("R9 rx pulse", 16'(rx_clk_pulse), 16'd1);
        chk("R9 tx pulse", 16'(tx_clk_pulse), 16'd1);
        chk("R9 no ovf", 16'(ovf_flag), 16'd0);
        rdchk("R9 reload", 3'd1, 8'hF0);
        cyc();
        chk("R9 single pulse", 16'(rx_clk_pulse), 16'd0);

        // R10: neighbour overflow passes through
        wreg(3'd0, 8'h10);
        quiet(); t1_ovf = 1'b1;
        #0.1;
        chk("R10 tx from neighbour", 16'(tx_clk_pulse), 16'd1);
        chk("R10 rx routed", 16'(rx_clk_pulse), 16'd0);
        cyc(); quiet();

        // R12: wrap and trigger in one cycle, capture operation
        wreg(3'd0, 8'h00); wreg(3'd1, 8'hFF); wreg(3'd2, 8'hFF); wreg(3'd0, 8'h0D);
        quiet(); tick = 1'b1; trig_pin = 1'b0; cyc(); quiet();
        rdchk("R12 count", 3'd1, 8'h00);
        rdchk("R12 hold lo", 3'd3, 8'hFF); rdchk("R12 hold hi", 3'd4, 8'hFF);
        rdchk("R12 flags", 3'd0, 8'hCD);

        // R13: unused address
        wreg(3'd5, 8'hAA);
        rdchk("R13 unused", 3'd5, 8'h00);
        rdchk("R13 ctrl untouched", 3'd0, 8'hCD);

        // random phase
        for (int i = 0; i < 6000; i++) begin
            tick     = 1'($urandom % 2);
            cnt_pin  = ($urandom % 4) != 0;
            trig_pin = ($urandom % 8) != 0;
            t1_ovf   = ($urandom % 6) == 0;
            wr_en    = ($urandom % 10) == 0;
            wr_addr  = 3'($urandom % 6);
            wr_data  = (wr_addr == 3'd2 || wr_addr == 3'd1) && ($urandom % 2 == 0)
                       ? 8'hFF : 8'($urandom);
            rd_sel   = 3'($urandom % 6);
            cyc();
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule